// File: doc/BRIEF.md
# Strobe-Framed Serial Command Receiver/Transmitter

This block is a synchronous serial slave for a three-wire link (data in, serial clock, strobe) with a separate data-out line. The host pulls strobe low to open a frame and then clocks bytes in. Each byte is sent least significant bit first and sampled on the serial clock's rising edge. The first complete byte of a frame is reported as a command. Every later byte in the same frame is reported as data. Each finished byte appears on a parallel port with a one-cycle valid pulse.

A command whose read-flag bit is set starts a read. The block asks the surrounding logic for a byte with a request pulse and takes the byte one cycle later. It then presents the byte on the data-out line, least significant bit first, changing on serial clock falling edges. It asks again after every eight bits. The data-out line is open-drain, so it is modelled as a drive-low enable that stays released whenever no read is in progress. Either edge of strobe resets the interface. Clock, strobe and data are synchronised into the system clock, which must run at least eight times faster than the serial clock.

Top module: `ser_cmd_slave`

## Requirements
- R1: Bits are taken on serial clock rising edges while strobe is low. The first bit received is bit 0. After eight bits, `rx_byte` holds the byte and `rx_valid` is high for exactly one system cycle.
- R2: The first byte completed after strobe falls has `rx_is_cmd` = 1. Every following byte in the same frame has `rx_is_cmd` = 0.
- R3: Serial clock edges while strobe is high produce no byte and leave no partial bits behind.
- R4: A frame that ends with fewer than eight bits in the current byte drops those bits. The next frame's first byte is decoded intact.
- R5: A command with bit 7 = 1 is a read command. `rd_req` is high in the same cycle as that command's `rx_valid`. `rd_data` is taken at the clock edge that ends the cycle after `rd_req`.
- R6: During a read, the byte is sent bit 0 first. Each bit changes after a serial clock falling edge, and `dout_low` = 1 means the line carries 0.
- R7: After each eight bits sent, `rd_req` pulses again for one cycle, and the new byte follows without a gap.
- R8: Either strobe edge ends any read, releases `dout_low` to 0 and clears the bit count. The next frame's first byte is again a command.
- R9: After reset, `rx_valid`, `rd_req` and `dout_low` are all 0.
- R10: A command with bit 7 = 0 raises no `rd_req`, and `dout_low` stays 0 through its frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_din | input | 1 | Serial data from host |
| ser_clk | input | 1 | Serial clock from host (idles high) |
| ser_stb | input | 1 | Frame strobe, active low |
| rx_valid | output | 1 | One-cycle pulse: `rx_byte` complete |
| rx_is_cmd | output | 1 | Completed byte is the frame's command |
| rx_byte | output | 8 | Received byte |
| rd_req | output | 1 | Request for the next read byte |
| rd_data | input | 8 | Read byte, valid the cycle after `rd_req` |
| dout_low | output | 1 | Drive-low enable of the open-drain data-out line |

## Verification
A read command's completion and the first read request fall in the same system cycle. Both come from the eighth rising edge of the command byte. The bench sends commands with bit 7 set and clear. Its monitor requires `rd_req` to be high exactly when a completed command byte has bit 7 set, and low on every other completion. A second meeting point is a strobe edge arriving while a read byte is half sent. The bench cuts a read after three bits and judges the release of the line and the decoding of the next frame.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/ser_sync_bit.sv
module ser_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            async_in,
  output ser_pkg::edge_t  ev
);
  logic lvl, prev;

  ser_sync_bit #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(async_in), .sync_out(lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign ev.lvl  = lvl;
  assign ev.rise = lvl & ~prev;
  assign ev.fall = ~lvl & prev;
endmodule

// File: rtl/ser_rx.sv
module ser_rx #(
  parameter int W      = 8,
  parameter int RD_BIT = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         din,
  input  logic         sclk_rise,
  input  logic         stb_lvl,
  input  logic         stb_rise,
  input  logic         stb_fall,
  output logic         rd_fire,
  output logic         valid,
  output logic         is_cmd,
  output logic [W-1:0] data
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;
  logic          first;
  logic [W-1:0]  nxt;
  logic          take, last;

  assign nxt     = {din, sr[W-1:1]};
  assign take    = sclk_rise && !stb_lvl && !stb_rise && !stb_fall;
  assign last    = (cnt == CW'(W-1));
  assign rd_fire = take && last && first && nxt[RD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0; cnt <= '0; first <= 1'b0;
      valid <= 1'b0; is_cmd <= 1'b0; data <= '0;
    end else begin
      valid <= 1'b0;
      if (stb_rise || stb_fall) begin
        cnt   <= '0;
        first <= stb_fall;
      end else if (take) begin
        sr <= nxt;
        if (last) begin
          cnt    <= '0;
          data   <= nxt;
          valid  <= 1'b1;
          is_cmd <= first;
          first  <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R1
  AST_STB_HIGH_QUIET: assert property (@(posedge clk) disable iff (rst)
    stb_lvl |=> !valid); // R3
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         sclk_fall,
  input  logic         stb_lvl,
  input  logic         stb_any,
  input  logic [W-1:0] rd_data,
  output logic         rd_req,
  output logic         dout_low
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;
  logic          active, load_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0; cnt <= '0; active <= 1'b0; load_pend <= 1'b0;
      rd_req <= 1'b0; dout_low <= 1'b0;
    end else begin
      rd_req    <= 1'b0;
      load_pend <= rd_req;
      if (stb_any) begin
        active    <= 1'b0;
        dout_low  <= 1'b0;
        cnt       <= '0;
        load_pend <= 1'b0;
      end else begin
        if (start) begin
          active <= 1'b1;
          rd_req <= 1'b1;
          cnt    <= '0;
        end
        if (load_pend) begin
          sr <= rd_data;
        end else if (active && !stb_lvl && sclk_fall) begin
          dout_low <= ~sr[0];
          sr       <= sr >> 1;
          if (cnt == CW'(W-1)) begin
            cnt    <= '0;
            rd_req <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  AST_EDGE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stb_any |=> (!dout_low && !rd_req)); // R8
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req); // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> !dout_low); // R10
endmodule

// File: rtl/ser_cmd_slave.sv
module ser_cmd_slave #(
  parameter int W           = 8,
  parameter int RD_BIT      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_din,
  input  logic         ser_clk,
  input  logic         ser_stb,
  output logic         rx_valid,
  output logic         rx_is_cmd,
  output logic [7:0]   rx_byte,
  output logic         rd_req,
  input  logic [7:0]   rd_data,
  output logic         dout_low
);
  import ser_pkg::*;

  localparam int N_EDGE = 2;

  logic [N_EDGE-1:0] raw;
  edge_t             ev [N_EDGE];
  logic              din_s, rd_fire;

  assign raw = {ser_stb, ser_clk};

  for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
    ser_edge_sync #(.STAGES(SYNC_STAGES)) u_es (
      .clk(clk), .rst(rst), .async_in(raw[g]), .ev(ev[g])
    );
  end

  ser_sync_bit #(.STAGES(SYNC_STAGES)) u_din (
    .clk(clk), .rst(rst), .async_in(ser_din), .sync_out(din_s)
  );

  ser_rx #(.W(W), .RD_BIT(RD_BIT)) u_rx (
    .clk(clk), .rst(rst), .din(din_s),
    .sclk_rise(ev[0].rise),
    .stb_lvl(ev[1].lvl), .stb_rise(ev[1].rise), .stb_fall(ev[1].fall),
    .rd_fire(rd_fire),
    .valid(rx_valid), .is_cmd(rx_is_cmd), .data(rx_byte)
  );

  ser_tx #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .start(rd_fire),
    .sclk_fall(ev[0].fall),
    .stb_lvl(ev[1].lvl), .stb_any(ev[1].rise | ev[1].fall),
    .rd_data(rd_data), .rd_req(rd_req), .dout_low(dout_low)
  );

  AST_REQ_WITH_RDCMD: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_is_cmd && rx_byte[RD_BIT]) |-> rd_req); // R5
  AST_NO_REQ_WRCMD: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_is_cmd && !rx_byte[RD_BIT]) |-> !rd_req); // R10
endmodule

// File: tb/ser_cmd_slave_tb.sv
`timescale 1ns/1ps
module ser_cmd_slave_tb_top;
  localparam int H = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic ser_din = 1'b0, ser_clk = 1'b1, ser_stb = 1'b1;
  logic rx_valid, rx_is_cmd, rd_req, dout_low;
  logic [7:0] rx_byte;
  logic [7:0] rd_data = 8'h00;

  int n_tests = 0, n_fail = 0;
  int n_valid = 0, n_req = 0, n_pair = 0;
  logic [8:0] exp_q[$];

  always #10 clk = ~clk;

  ser_cmd_slave dut_i (
    .clk(clk), .rst(rst), .ser_din(ser_din), .ser_clk(ser_clk), .ser_stb(ser_stb),
    .rx_valid(rx_valid), .rx_is_cmd(rx_is_cmd), .rx_byte(rx_byte),
    .rd_req(rd_req), .rd_data(rd_data), .dout_low(dout_low)
  );

  function automatic logic [7:0] rd_val(int i);
    return 8'h5A + 8'(i * 51);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // read-data responder (R5): byte ready at edge after rd_req
  always @(posedge clk) begin
    if (!rst && rd_req) begin
      rd_data <= rd_val(n_req);
      n_req   <= n_req + 1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      n_valid++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected byte", {rx_is_cmd, rx_byte}, 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({rx_is_cmd, rx_byte} == e, "R1/R2 byte", {rx_is_cmd, rx_byte}, e);
      end
      if (rx_is_cmd) begin
        check(rd_req == rx_byte[7], "R5/R10 req with cmd", rd_req, rx_byte[7]);
        if (rd_req) n_pair++;
      end
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic line);
    ser_clk = 1'b0; ser_din = b;
    wait_n(H);
    line = ~dout_low;
    ser_clk = 1'b1;
    wait_n(H);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic cmd, input bit expect_it,
                      output logic [7:0] rx);
    if (expect_it) exp_q.push_back({cmd, tx});
    for (int i = 0; i < 8; i++) send_bit(tx[i], rx[i]);
  endtask

  task automatic frame_open();
    ser_stb = 1'b0; wait_n(H);
  endtask

  task automatic frame_close();
    ser_stb = 1'b1; wait_n(2*H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    logic b;
    int v0, r0;
    wait_n(5); rst = 1'b0; wait_n(1);
    // R9 reset state
    check(rx_valid == 1'b0, "R9 rx_valid", rx_valid, 0);
    check(rd_req == 1'b0, "R9 rd_req", rd_req, 0);
    check(dout_low == 1'b0, "R9 dout_low", dout_low, 0);
    wait_n(2*H);

    // R1, R2: write frame
    frame_open();
    xfer(8'h40, 1'b1, 1, rx);
    xfer(8'h12, 1'b0, 1, rx);
    xfer(8'hF0, 1'b0, 1, rx);
    xfer(8'h81, 1'b0, 1, rx);
    frame_close();
    check(exp_q.size() == 0, "R1 all bytes seen", exp_q.size(), 0);
    check(n_valid == 4, "R2 byte count", n_valid, 4);
    check(n_req == 0, "R10 no req for write cmd", n_req, 0);

    // R3: clocks with strobe high
    v0 = n_valid;
    for (int i = 0; i < 20; i++) begin
      ser_din = i[0]; ser_clk = 1'b0; wait_n(H); ser_clk = 1'b1; wait_n(H);
    end
    check(n_valid == v0, "R3 no byte while strobe high", n_valid, v0);
    frame_open();
    xfer(8'h03, 1'b1, 1, rx);
    frame_close();
    check(exp_q.size() == 0 && n_valid == v0 + 1, "R3 clean command after", n_valid, v0 + 1);

    // R4: partial byte dropped
    v0 = n_valid;
    frame_open();
    for (int i = 0; i < 5; i++) send_bit(1'b1, b);
    frame_close();
    check(n_valid == v0, "R4 partial no byte", n_valid, v0);
    frame_open();
    xfer(8'h22, 1'b1, 1, rx);
    xfer(8'hC5, 1'b0, 1, rx);
    frame_close();
    check(exp_q.size() == 0 && n_valid == v0 + 2, "R4 next frame intact", n_valid, v0 + 2);

    // R5, R6, R7: read frame
    r0 = n_req;
    frame_open();
    xfer(8'h85, 1'b1, 1, rx);
    check(n_pair == 1, "R5 req in cmd cycle", n_pair, 1);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, 1'b0, 1, rx);
      check(rx == rd_val(r0 + k), "R6 read byte", rx, rd_val(r0 + k));
    end
    check(n_req == r0 + 4, "R7 request per byte", n_req, r0 + 4);
    // R8: abort mid-byte
    for (int i = 0; i < 3; i++) send_bit(1'b0, b);
    frame_close();
    check(dout_low == 1'b0, "R8 line released", dout_low, 0);
    check(exp_q.size() == 0, "R8 no stray byte", exp_q.size(), 0);

    // R8/R10: new frame is a write command, line stays released
    r0 = n_req;
    frame_open();
    xfer(8'h10, 1'b1, 1, rx);
    xfer(8'h00, 1'b0, 1, rx);
    check(rx == 8'hFF, "R10 line released in write frame", rx, 8'hFF);
    frame_close();
    check(n_req == r0, "R10 no request", n_req, r0);
    check(exp_q.size() == 0, "R8 command after abort", exp_q.size(), 0);

    // second read frame: strobe fall resets, counting restarts
    r0 = n_req;
    frame_open();
    xfer(8'hA0, 1'b1, 1, rx);
    xfer(8'h00, 1'b0, 1, rx);
    check(rx == rd_val(r0), "R6 read after abort", rx, rd_val(r0));
    frame_close();
    check(dout_low == 1'b0, "R8 released at frame end", dout_low, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule